// File: doc/BRIEF.md
# Packed SIMD Leading-Bit Counter

This unit takes a 64-bit or 128-bit packed operand and splits it into equal lanes of 8, 16 or 32 bits. For each lane it writes one count into the same lane of the result. A mode input chooses what is counted. In zero mode the unit counts leading zero bits. In sign mode it counts the run of bits directly below the lane's top bit that equal the top bit. The top bit itself is not part of that count.

A two-bit size code sets the lane width to 8 shifted left by the code. A width select picks a 64-bit or a 128-bit operand. Size code 3 is an illegal encoding: the unit reports it on an undefined flag and returns no count data.

Operands enter through a valid/ready handshake. The result leaves from a single register stage. Latency is the same for every operand value.

Top module: `lead_count_simd`

## Requirements
- R1: The lane width is 8 << `in_size` (codes 0, 1, 2 give 8, 16, 32 bits). Lane k occupies result bits [k*LW +: LW], and its count is zero-extended to the lane width.
- R2: With `in_zero_mode` = 1, each lane holds the number of consecutive zero bits counted from its top bit down. An all-zero lane yields the full lane width.
- R3: With `in_zero_mode` = 0, each lane holds the number of consecutive bits just below the top bit that equal the top bit, with the top bit not counted. An all-zero or all-ones lane yields the lane width minus 1.
- R4: With `in_wide` = 0, only operand bits [63:0] are processed and `out_data[127:64]` is zero.
- R5: With `in_wide` = 1, all 128 operand bits are processed, giving 128/LW lanes.
- R6: Size code 3 sets `out_undef` = 1 with `out_data` all zero.
- R7: Any legal size code (0, 1, 2) gives `out_undef` = 0.
- R8: An input accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` = 1 after that same edge. Latency is one cycle for every operand value.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the outputs hold their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand |
| in_opnd | input | 128 | Packed operand (bits [63:0] only when narrow) |
| in_size | input | 2 | Lane size code; 3 is illegal |
| in_wide | input | 1 | 1 selects 128-bit operand, 0 selects 64-bit |
| in_zero_mode | input | 1 | 1 counts leading zeros, 0 counts leading sign bits |
| out_valid | output | 1 | Result held in the output stage |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 128 | Packed per-lane counts |
| out_undef | output | 1 | Result came from an illegal size code |

## Verification
The assertions assume that `out_ready` and the input fields are known, 0 or 1, whenever they are sampled. They also assume that the upstream side may drop or change `in_valid` at any time, since no property relies on the input being held. The bench drives every input from defined values at the falling edge and never leaves a field unknown. It mixes size codes, including the illegal code 3, and toggles `out_ready` only in the directed stall sequence, so that every handshake case the properties cover is reached.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
   localparam int LCS_DATA_W     = 128;
   localparam int LCS_MIN_LANE_W = 8;
   localparam int LCS_N_SIZES    = 3;

   typedef enum logic {
      MODE_SIGN = 1'b0,
      MODE_ZERO = 1'b1
   } cnt_mode_e;
endpackage

// File: rtl/lcs_lane_count.sv
module lcs_lane_count
   import lcs_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic [LW-1:0] lane_in,
   input  cnt_mode_e     mode,
   output logic [LW-1:0] lane_cnt
);
   localparam int CW = $clog2(LW) + 1;

   logic [LW-1:0] scan;
   logic [CW-1:0] cnt;
   logic          found;

   // Sign mode: bit i of scan marks a change between v[i-1] and v[i];
   // a forced 1 at the bottom caps the count at LW-1.
   assign scan = (mode == MODE_ZERO) ? lane_in
                                     : {lane_in[LW-2:0] ^ lane_in[LW-1:1], 1'b1};

   always_comb begin
      cnt   = CW'(LW);
      found = 1'b0;
      for (int i = LW - 1; i >= 0; i--) begin
         if (!found && scan[i]) begin
            cnt   = CW'(LW - 1 - i);
            found = 1'b1;
         end
      end
   end

   assign lane_cnt = {{(LW-CW){1'b0}}, cnt};
endmodule

// File: rtl/lcs_lane_row.sv
module lcs_lane_row
   import lcs_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int LW     = 8
) (
   input  logic [DATA_W-1:0] opnd,
   input  cnt_mode_e         mode,
   output logic [DATA_W-1:0] counts
);
   localparam int N_LANES = DATA_W / LW;

   if (DATA_W % LW != 0) begin : g_bad_split
      $error("lcs_lane_row: DATA_W must be a multiple of LW");
   end

   for (genvar k = 0; k < N_LANES; k++) begin : g_lane
      lcs_lane_count #(.LW(LW)) u_cnt (
         .lane_in  (opnd[k*LW +: LW]),
         .mode     (mode),
         .lane_cnt (counts[k*LW +: LW])
      );
   end
endmodule

// File: rtl/lead_count_simd.sv
module lead_count_simd
   import lcs_pkg::*;
#(
   parameter int DATA_W     = LCS_DATA_W,
   parameter int MIN_LANE_W = LCS_MIN_LANE_W,
   parameter int N_SIZES    = LCS_N_SIZES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_opnd,
   input  logic [1:0]        in_size,
   input  logic              in_wide,
   input  logic              in_zero_mode,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_undef
);
   localparam int HALF_W     = DATA_W / 2;
   localparam int MAX_LANE_W = MIN_LANE_W << (N_SIZES - 1);

   if (N_SIZES < 1 || N_SIZES > 3) begin : g_bad_sizes
      $error("lead_count_simd: N_SIZES must be 1..3 for a 2-bit size code");
   end
   if (HALF_W % MAX_LANE_W != 0) begin : g_bad_width
      $error("lead_count_simd: half width must hold whole widest lanes");
   end
   if (MIN_LANE_W < 4) begin : g_bad_lane
      $error("lead_count_simd: lanes narrower than 4 bits unsupported");
   end

   cnt_mode_e         mode;
   logic [DATA_W-1:0] row_res [N_SIZES];
   logic [DATA_W-1:0] sel_res;
   logic [DATA_W-1:0] next_data;
   logic              illegal;
   logic              accept;

   assign mode = cnt_mode_e'(in_zero_mode);

   for (genvar g = 0; g < N_SIZES; g++) begin : g_row
      lcs_lane_row #(.DATA_W(DATA_W), .LW(MIN_LANE_W << g)) u_row (
         .opnd   (in_opnd),
         .mode   (mode),
         .counts (row_res[g])
      );
   end

   assign illegal = (32'(in_size) >= N_SIZES);

   always_comb begin
      sel_res = '0;
      for (int g = 0; g < N_SIZES; g++) begin
         if (32'(in_size) == g) sel_res = row_res[g];
      end
   end

   always_comb begin
      if (illegal)      next_data = '0;
      else if (in_wide) next_data = sel_res;
      else              next_data = {{HALF_W{1'b0}}, sel_res[HALF_W-1:0]};
   end

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_undef <= 1'b0;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_data  <= next_data;
         out_undef <= illegal;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
   parameter int DATA_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [1:0]        in_size,
   input logic              in_wide,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_undef
);
   localparam int HALF_W = DATA_W / 2;

   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_undef)));

   assert_undef_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_size == 2'd3) |=> (out_undef && out_data == '0));

   assert_undef_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_size != 2'd3) |=> !out_undef);

   assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_wide) |=> (out_data[DATA_W-1:HALF_W] == '0));
endmodule

bind lead_count_simd lcs_checker #(.DATA_W(DATA_W)) u_lcs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_size   (in_size),
   .in_wide   (in_wide),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_undef (out_undef)
);

// File: tb/sim_lead_count_simd.sv
`timescale 1ns/1ps
module sim_lead_count_simd;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_opnd = '0;
   logic [1:0]   in_size = '0;
   logic         in_wide = 1'b0;
   logic         in_zero_mode = 1'b0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;
   logic         out_undef;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   lead_count_simd u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_opnd(in_opnd), .in_size(in_size), .in_wide(in_wide),
      .in_zero_mode(in_zero_mode), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_undef(out_undef)
   );

   function automatic logic [127:0] ref_res(logic [127:0] a, int sz, bit q, bit u);
      logic [127:0] res = '0;
      int lw  = 8 << sz;
      int tot = q ? 128 : 64;
      if (sz == 3) return '0;
      for (int base = 0; base < tot; base += lw) begin
         int c = 0;
         bit stop = 0;
         if (u) begin
            for (int k = lw - 1; k >= 0; k--)
               if (!stop && a[base+k] == 1'b0) c++; else stop = 1;
         end else begin
            for (int k = lw - 2; k >= 0; k--)
               if (!stop && a[base+k] == a[base+lw-1]) c++; else stop = 1;
         end
         for (int k = 0; k < lw; k++) res[base+k] = c[k];
      end
      return res;
   endfunction

   task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One transfer with out_ready high; result checked at the next falling edge.
   task automatic run_one(logic [127:0] a, int sz, bit q, bit u, string tag);
      logic [127:0] exp;
      exp = ref_res(a, sz, q, u);
      @(negedge clk);
      in_opnd = a; in_size = 2'(sz); in_wide = q; in_zero_mode = u; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, {tag, " R8 valid"}, 128'(out_valid), 128'd1);
      check(out_data == exp, tag, out_data, exp);
      check(out_undef == (sz == 3), {tag, " R6/R7 undef"}, 128'(out_undef), 128'(sz == 3));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] a, b, expa, expb;
      void'($urandom(32'd20240611));
      repeat (2) @(negedge clk);
      // R10 reset state
      check(out_valid == 1'b0, "R10 out_valid", 128'(out_valid), 128'd0);
      check(in_ready == 1'b1, "R10 in_ready", 128'(in_ready), 128'd1);
      @(negedge clk); rst_n = 1'b1;

      // R2 zero mode corner cases
      run_one('0, 0, 1, 1, "R2 all-zero 8b");
      run_one('0, 2, 1, 1, "R2 all-zero 32b");
      run_one({16{8'h01}}, 0, 1, 1, "R2 one-in-lsb");
      run_one({4{32'h8000_0000}}, 2, 1, 1, "R2 top-set");
      // R3 sign mode corner cases
      run_one('1, 0, 1, 0, "R3 all-ones 8b");
      run_one('0, 1, 1, 0, "R3 all-zero 16b");
      run_one({8{16'hC000}}, 1, 1, 0, "R3 two-ones");
      run_one({16{8'h40}}, 0, 1, 0, "R3 sign-flip");
      run_one({4{32'hFFFF_FFFE}}, 2, 1, 0, "R3 long-run");
      // R1 lanes in place with mixed lane contents
      run_one(128'h00_01_02_04_08_10_20_40_80_FF_7F_3F_1F_0F_07_03, 0, 1, 1, "R1 byte lanes");
      run_one(128'h0001_8000_00F0_FFFF_0000_7FFF_0100_0010, 1, 1, 0, "R1 half lanes");
      // R4 narrow operand, upper bits must be ignored
      run_one({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 0, 1, "R4 narrow");
      run_one({64'h0123_4567_89AB_CDEF, 64'h0}, 2, 0, 1, "R4 upper ignored");
      // R5 wide operand top lane
      run_one({32'h0000_0001, 96'h0}, 2, 1, 1, "R5 top lane");
      // R6 illegal size
      run_one('1, 3, 1, 1, "R6 illegal wide");
      run_one(128'h1234, 3, 0, 0, "R6 illegal narrow");

      // R9 stall: output held, input blocked, then next item flows
      a = {8{16'h0F00}}; b = {16{8'hF0}};
      expa = ref_res(a, 1, 1, 1); expb = ref_res(b, 0, 1, 0);
      @(negedge clk);
      out_ready = 1'b0;
      in_opnd = a; in_size = 2'd1; in_wide = 1'b1; in_zero_mode = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      in_opnd = b; in_size = 2'd0; in_zero_mode = 1'b0;
      check(in_ready == 1'b0, "R9 ready low", 128'(in_ready), 128'd0);
      repeat (2) @(negedge clk);
      check(out_valid == 1'b1 && out_data == expa, "R9 held", out_data, expa);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1 && out_data == expb, "R9 next after stall", out_data, expb);
      @(negedge clk);
      check(out_valid == 1'b0, "R8 drained", 128'(out_valid), 128'd0);

      // Random mix of layouts, modes and run lengths
      for (int it = 0; it < 400; it++) begin
         logic [127:0] r;
         int sz;
         for (int w = 0; w < 4; w++) begin
            logic [31:0] word;
            word = $urandom >> ($urandom % 32);
            if ($urandom % 2) word = ~word;
            r[w*32 +: 32] = word;
         end
         sz = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
         run_one(r, sz, 1'($urandom), 1'($urandom), "R1 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule